// File: doc/BRIEF.md
# Conditional trap comparison unit

This unit decides whether a conditional trap instruction fires. It compares two operands both signed and unsigned. It masks the results with a five-bit condition field taken from the instruction word, and raises a take-trap flag when any selected relation holds. A separate five-bit forced-kind input forces the trap whenever it is nonzero. The forced kinds cover trap causes that do not depend on a comparison.

The unit is purely combinational and has no clock or reset. The outputs follow the inputs in the same cycle, so the unit can sit inside an execute stage of a pipeline. A narrow-mode flag selects whether the comparisons use only the low half of each operand or the full operand width. The five relation results are also brought out as a vector for observation.

Top module: `trap_cond_unit`

## Requirements
- R1: The condition field is `insn_word[25:21]`. Field bit 4 (`insn_word[25]`) selects signed-less-than and field bit 0 (`insn_word[21]`) selects unsigned-greater-than. No other instruction bit affects either output.
- R2: When `narrow_mode` is 1, the signed relations compare the low 32 bits of each operand after sign extension to 64 bits.
- R3: When `narrow_mode` is 1, the unsigned relations and equality compare the low 32 bits zero-extended. Bits 63:32 of both operands then have no effect on either output.
- R4: When `narrow_mode` is 0, all relations use the full 64-bit operands.
- R5: `rel_flags` is ordered with bit 4 = signed less-than, bit 3 = signed greater-than, bit 2 = equal, bit 1 = unsigned less-than and bit 0 = unsigned greater-than, all with a as the left operand.
- R6: With `force_kind` zero, `take_trap` is 1 exactly when `rel_flags & field` is nonzero.
- R7: Any nonzero `force_kind` drives `take_trap` to 1 whatever the operands and field are.
- R8: A condition field of 5'b11111 always takes the trap.
- R9: Exactly one of {signed less, signed greater, equal} is set, and exactly one of {unsigned less, unsigned greater, equal} is set.
- R10: The outputs are a combinational function of the present inputs and are valid in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 64 | Left comparison operand |
| opnd_b | input | 64 | Right comparison operand |
| narrow_mode | input | 1 | 1: compare the low 32 bits only |
| insn_word | input | 32 | Instruction word that carries the condition field |
| force_kind | input | 5 | Forced trap causes; a nonzero value forces the trap |
| take_trap | output | 1 | The trap fires |
| rel_flags | output | 5 | Relation results in the order given by R5 |

## Verification
The unit holds no state, so a fault cannot hide and then surface later. A wrong extension, a swapped relation or a misplaced field shows on `rel_flags` or `take_trap` in the same cycle that the offending operands are applied. The corner operands are 32'h80000000 and 32'hFFFFFFFF in narrow mode, together with upper halves that differ. These split the signed and unsigned orderings, and they expose sign handling and truncation errors right away.

// File: rtl/trap_cond_unit.sv
module trap_cond_unit #(
  parameter int DATA_W   = 64,
  parameter int HALF_W   = 32,
  parameter int INSN_W   = 32,
  parameter int FIELD_LO = 21,
  parameter int KIND_W   = 5
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              narrow_mode,
  input  logic [INSN_W-1:0] insn_word,
  input  logic [KIND_W-1:0] force_kind,
  output logic              take_trap,
  output logic [4:0]        rel_flags
);
  localparam int UPPER_W = DATA_W - HALF_W;

  logic [4:0]        field;
  logic [DATA_W-1:0] sa, sb, za, zb;
  logic              slt, sgt, eq, ult, ugt;

  assign field = insn_word[FIELD_LO +: 5];

  assign sa = narrow_mode ? {{UPPER_W{opnd_a[HALF_W-1]}}, opnd_a[HALF_W-1:0]} : opnd_a;
  assign sb = narrow_mode ? {{UPPER_W{opnd_b[HALF_W-1]}}, opnd_b[HALF_W-1:0]} : opnd_b;
  assign za = narrow_mode ? {{UPPER_W{1'b0}}, opnd_a[HALF_W-1:0]} : opnd_a;
  assign zb = narrow_mode ? {{UPPER_W{1'b0}}, opnd_b[HALF_W-1:0]} : opnd_b;

  assign slt = $signed(sa) < $signed(sb);
  assign sgt = $signed(sa) > $signed(sb);
  assign ult = za < zb;
  assign ugt = za > zb;
  assign eq  = za == zb;

  assign rel_flags = {slt, sgt, eq, ult, ugt};
  assign take_trap = (|force_kind) | (|(rel_flags & field));
endmodule

// File: rtl/trap_cond_unit_chk.sv
module trap_cond_unit_chk #(
  parameter int DATA_W   = 64,
  parameter int INSN_W   = 32,
  parameter int FIELD_LO = 21,
  parameter int KIND_W   = 5
) (
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [INSN_W-1:0] insn_word,
  input logic [KIND_W-1:0] force_kind,
  input logic              take_trap,
  input logic [4:0]        rel_flags
);
  always_comb begin
    a_r9_signed_one_hot: assert ($countones({rel_flags[4], rel_flags[3], rel_flags[2]}) == 1);
    a_r9_unsigned_one_hot: assert ($countones({rel_flags[2], rel_flags[1], rel_flags[0]}) == 1);
    if (force_kind != '0)
      a_r7_forced_fires: assert (take_trap);
    if (insn_word[FIELD_LO +: 5] == 5'b11111)
      a_r8_all_ones_fires: assert (take_trap);
    if (force_kind == '0 && insn_word[FIELD_LO +: 5] == 5'b00000)
      a_r6_empty_field_quiet: assert (!take_trap);
    if (opnd_a == opnd_b)
      a_r5_equal_operands: assert (rel_flags == 5'b00100);
  end
endmodule

bind trap_cond_unit trap_cond_unit_chk #(
  .DATA_W(DATA_W), .INSN_W(INSN_W), .FIELD_LO(FIELD_LO), .KIND_W(KIND_W)
) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .insn_word(insn_word),
  .force_kind(force_kind), .take_trap(take_trap), .rel_flags(rel_flags)
);

// File: tb/tb_trap_cond_unit.sv
module tb_trap_cond_unit;
  logic        clk = 1'b0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic        narrow_mode = 1'b0;
  logic [31:0] insn_word = '0;
  logic [4:0]  force_kind = '0;
  logic        take_trap;
  logic [4:0]  rel_flags;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  trap_cond_unit dut (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .narrow_mode(narrow_mode),
    .insn_word(insn_word), .force_kind(force_kind),
    .take_trap(take_trap), .rel_flags(rel_flags)
  );

  function automatic logic [4:0] ref_flags(logic [63:0] a, logic [63:0] b, logic n);
    longint sa, sb;
    logic [63:0] ua, ub;
    if (n) begin
      sa = longint'(int'(a[31:0])); sb = longint'(int'(b[31:0]));
      ua = 64'(a[31:0]);            ub = 64'(b[31:0]);
    end else begin
      sa = longint'(a); sb = longint'(b); ua = a; ub = b;
    end
    return {sa < sb, sa > sb, ua == ub, ua < ub, ua > ub};
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic n,
                       input logic [31:0] insn, input logic [4:0] fk, input string req);
    logic [4:0] ef;
    logic et;
    @(negedge clk);
    opnd_a = a; opnd_b = b; narrow_mode = n; insn_word = insn; force_kind = fk;
    #5;
    ef = ref_flags(a, b, n);
    et = (fk != 0) || ((ef & insn[25:21]) != 0);
    checks++;
    if (rel_flags !== ef || take_trap !== et) begin
      errors++;
      $display("FAIL %s flags=%b take=%b expected flags=%b take=%b", req, rel_flags, take_trap, ef, et);
    end
  endtask

  function automatic logic [31:0] mk(logic [4:0] f, logic [31:0] rest);
    return (rest & ~32'h03E0_0000) | (32'(f) << 21);
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10 idle inputs: equal operands, empty field
    apply('0, '0, 1'b0, '0, '0, "R10 idle");
    // R1 field position with noise around it
    apply(64'd1, 64'd2, 1'b0, mk(5'b00010, 32'hFC1F_FFFF), '0, "R1 field ult");
    apply(64'd1, 64'd2, 1'b0, mk(5'b00001, 32'hFFFF_FFFF), '0, "R1 field ugt miss");
    // R2 narrow signed: 0x80000000 is negative
    apply(64'h0000_0000_8000_0000, 64'h1, 1'b1, mk(5'b10000, 0), '0, "R2 narrow slt");
    apply(64'h0000_0000_FFFF_FFFF, 64'h0, 1'b1, mk(5'b10000, 0), '0, "R2 narrow minus one");
    // R3 narrow unsigned, upper halves ignored
    apply(64'h0000_0000_FFFF_FFFF, 64'h0, 1'b1, mk(5'b00001, 0), '0, "R3 narrow ugt");
    apply(64'hDEAD_BEEF_0000_0005, 64'h1234_5678_0000_0005, 1'b1, mk(5'b00100, 0), '0, "R3 upper ignored");
    apply(64'h7FFF_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 1'b1, mk(5'b01010, 0), '0, "R3 R2 split");
    // R4 wide mode uses upper bits
    apply(64'hDEAD_BEEF_0000_0005, 64'h1234_5678_0000_0005, 1'b0, mk(5'b01001, 0), '0, "R4 wide");
    apply(64'h8000_0000_0000_0000, 64'h1, 1'b0, mk(5'b10001, 0), '0, "R4 wide min");
    // R5 ordering
    apply(64'h5, 64'h9, 1'b0, mk(5'b00000, 0), '0, "R5 order lt");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h3, 1'b0, mk(5'b00000, 0), '0, "R5 order mixed");
    // R6 masking
    apply(64'h9, 64'h5, 1'b0, mk(5'b10110, 0), '0, "R6 masked out");
    // R7 forced
    apply(64'h9, 64'h5, 1'b0, mk(5'b00000, 0), 5'b10000, "R7 force hi");
    apply(64'h9, 64'h9, 1'b1, mk(5'b00000, 0), 5'b00001, "R7 force lo");
    // R8 all ones
    apply(64'h0000_0000_8000_0000, 64'hFFFF_FFFF_8000_0000, 1'b1, mk(5'b11111, 0), '0, "R8 all ones eq");
    apply(64'h3, 64'h7, 1'b0, mk(5'b11111, 0), '0, "R8 all ones lt");
    // R9 random coverage
    for (int i = 0; i < 400; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = (i % 4 == 0) ? ra : {$urandom, $urandom};
      if (i % 8 == 1) rb[31:0] = ra[31:0];
      apply(ra, rb, 1'(i % 2), $urandom, (i % 5 == 0) ? 5'($urandom) : 5'd0, "R9 random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule